// File: doc/BRIEF.md
# Chained Default Configuration Sequencer

After a master reset, this block loads a default setup into its own registers. Loading begins only when its chain-enable input is low. The sequence runs for a fixed, parameterised number of clock cycles. During that time the block writes one descriptor per queue and then a queue-count register. The default setup always uses the largest queue count the block supports. It divides the memory into equal slices, placed one after another from address zero.

When loading is complete, the chain-enable output falls from high to low and stays low until the next reset. Several instances can be linked in a row: each output drives the input of the next device, and the first device has its input tied low. The output of the last device falling low means every device in the row is configured and normal traffic may start. A single stand-alone device has its input held low.

The queue count and the per-queue base and size are presented on outputs. These outputs read zero until the output enable has fallen.

Top module: `cfg_chain_seq`

## Requirements
- R1: While `rst_n` is low, `chain_out_n` is high, and it goes high as soon as `rst_n` falls, without waiting for a clock edge.
- R2: After reset, while `chain_in_n` stays high, the block stays idle and `chain_out_n` stays high for any number of cycles.
- R3: With reset long released, `chain_out_n` is low after exactly LOAD_CYCLES+1 rising edges, counted from the first edge that samples `chain_in_n` low. If LOAD_CYCLES is below NUM_Q+1, NUM_Q+1 is used in its place.
- R4: Once loading has begun, `chain_in_n` has no further effect. After completion, `chain_out_n` stays low and the table outputs stay unchanged until reset.
- R5: After completion, `q_count` equals NUM_Q.
- R6: After completion, queue i (field bits [i*AW +: AW] of `q_base`, where AW = clog2(MEM_WORDS)) has base i*(MEM_WORDS/NUM_Q). Its size field (bits [i*SW +: SW] of `q_size`, where SW = clog2(MEM_WORDS+1)) equals MEM_WORDS/NUM_Q.
- R7: While `chain_out_n` is high, `q_count`, `q_base` and `q_size` all read zero.
- R8: In a row of devices where each `chain_out_n` feeds the next `chain_in_n`, device k (counting from 1) drives its output low k*(LOAD_CYCLES+1) edges after the first device samples its input low.
- R9: A reset applied partway through loading returns `chain_out_n` high and clears the table outputs. After release, the full sequence runs again from the start.
- R10: The release of `rst_n` is synchronised over two edges. With `chain_in_n` held low, `chain_out_n` falls after exactly LOAD_CYCLES+3 rising edges, counted from the release of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Master reset, active low, asynchronous assert |
| chain_in_n | input | 1 | Chain enable in; low allows loading to start |
| chain_out_n | output | 1 | Chain enable out; high while unconfigured, low when done |
| q_count | output | clog2(NUM_Q+1) | Configured number of queues |
| q_base | output | NUM_Q*clog2(MEM_WORDS) | Packed base address of each queue |
| q_size | output | NUM_Q*clog2(MEM_WORDS+1) | Packed size of each queue in words |

## Verification
The hardest case to reach from the ports is a reset that lands in the middle of loading. In that case some descriptors are already written internally but still hidden. The stimulus first starts a sequence, then pulls reset low a few edges in, away from any clock edge. It checks that the output returns high and the table reads zero at once. It then checks that the restarted run takes the full, synchronised length. The three-device row is driven from one input, so the handoff latency of every stage is measured at its own output.

// File: rtl/cfg_chain_seq_pkg.sv
package cfg_chain_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_DONE = 2'd2
  } seq_state_t;
endpackage

// File: rtl/cfgseq_rst_sync.sv
module cfgseq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      srst_n  <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      srst_n  <= stage_q;
    end
  end
endmodule

// File: rtl/cfgseq_fsm.sv
module cfgseq_fsm
  import cfg_chain_seq_pkg::*;
#(
  parameter int NUM_Q       = 4,
  parameter int LOAD_CYCLES = 8
) (
  input  logic                         clk,
  input  logic                         srst_n,
  input  logic                         chain_in_n,
  output logic                         wr_en,
  output logic [$clog2(NUM_Q+1)-1:0]   wr_sel,
  output logic                         done
);
  localparam int EFF_CYCLES = (LOAD_CYCLES > NUM_Q) ? LOAD_CYCLES : NUM_Q + 1;
  localparam int CNT_W      = $clog2(EFF_CYCLES);
  localparam int SEL_W      = $clog2(NUM_Q + 1);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(EFF_CYCLES - 1);
  localparam logic [CNT_W-1:0] TBL_STEPS = CNT_W'(NUM_Q);

  seq_state_t       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  // next-state logic
  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (!chain_in_n) begin
          st_d   = ST_LOAD;
          cnt_d  = '0;
          cnt_en = 1'b1;
        end
      end
      ST_LOAD: begin
        if (cnt_q == LAST_STEP) begin
          st_d = ST_DONE;
        end else begin
          cnt_d  = cnt_q + 1'b1;
          cnt_en = 1'b1;
        end
      end
      ST_DONE: st_d = ST_DONE;
      default: st_d = ST_IDLE;
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  // step counter with explicit enable
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign wr_en  = (st_q == ST_LOAD) && (cnt_q <= TBL_STEPS);
  assign wr_sel = cnt_q[SEL_W-1:0];
  assign done   = (st_q == ST_DONE);

  // R2: idle holds while the chain enable is inactive
  a_r2_wait_for_enable: assert property (@(posedge clk) disable iff (!srst_n)
    (st_q == ST_IDLE && chain_in_n) |=> (st_q == ST_IDLE));

  // R3: the step counter never passes the final step
  a_r3_step_bound: assert property (@(posedge clk) disable iff (!srst_n)
    (st_q == ST_LOAD) |-> (cnt_q <= LAST_STEP));

  // R4: a started sequence never returns to idle
  a_r4_no_restart: assert property (@(posedge clk) disable iff (!srst_n)
    (st_q != ST_IDLE) |=> (st_q != ST_IDLE));

  // R4: completion is sticky
  a_r4_done_sticky: assert property (@(posedge clk) disable iff (!srst_n)
    done |=> done);
endmodule

// File: rtl/cfgseq_qtable.sv
module cfgseq_qtable #(
  parameter int NUM_Q     = 4,
  parameter int MEM_WORDS = 4096
) (
  input  logic                                      clk,
  input  logic                                      srst_n,
  input  logic                                      wr_en,
  input  logic [$clog2(NUM_Q+1)-1:0]                wr_sel,
  input  logic                                      valid,
  output logic [$clog2(NUM_Q+1)-1:0]                q_count_o,
  output logic [NUM_Q*$clog2(MEM_WORDS)-1:0]        q_base_o,
  output logic [NUM_Q*$clog2(MEM_WORDS+1)-1:0]      q_size_o
);
  localparam int SEL_W  = $clog2(NUM_Q + 1);
  localparam int ADDR_W = $clog2(MEM_WORDS);
  localparam int SIZE_W = $clog2(MEM_WORDS + 1);
  localparam int QSIZE  = MEM_WORDS / NUM_Q;

  logic [SEL_W-1:0] count_q;
  logic             count_ld;

  assign count_ld = wr_en && (wr_sel == SEL_W'(NUM_Q));

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)       count_q <= '0;
    else if (count_ld) count_q <= SEL_W'(NUM_Q);
  end

  assign q_count_o = valid ? count_q : '0;

  for (genvar gi = 0; gi < NUM_Q; gi++) begin : g_q
    localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(gi * QSIZE);
    localparam logic [SIZE_W-1:0] SIZE_V = SIZE_W'(QSIZE);
    logic [ADDR_W-1:0] base_q;
    logic [SIZE_W-1:0] size_q;
    logic              ld;

    assign ld = wr_en && (wr_sel == SEL_W'(gi));

    always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n) begin
        base_q <= '0;
        size_q <= '0;
      end else if (ld) begin
        base_q <= BASE_V;
        size_q <= SIZE_V;
      end
    end

    assign q_base_o[gi*ADDR_W +: ADDR_W] = valid ? base_q : '0;
    assign q_size_o[gi*SIZE_W +: SIZE_W] = valid ? size_q : '0;
  end

  // R6: writes only ever address a descriptor or the count register
  a_r6_write_in_range: assert property (@(posedge clk) disable iff (!srst_n)
    wr_en |-> (wr_sel <= SEL_W'(NUM_Q)));
endmodule

// File: rtl/cfg_chain_seq.sv
module cfg_chain_seq #(
  parameter int NUM_Q       = 4,
  parameter int MEM_WORDS   = 4096,
  parameter int LOAD_CYCLES = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 chain_in_n,
  output logic                                 chain_out_n,
  output logic [$clog2(NUM_Q+1)-1:0]           q_count,
  output logic [NUM_Q*$clog2(MEM_WORDS)-1:0]   q_base,
  output logic [NUM_Q*$clog2(MEM_WORDS+1)-1:0] q_size
);
  localparam int SEL_W = $clog2(NUM_Q + 1);

  logic             srst_n;
  logic             wr_en;
  logic [SEL_W-1:0] wr_sel;
  logic             done;

  cfgseq_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  cfgseq_fsm #(
    .NUM_Q       (NUM_Q),
    .LOAD_CYCLES (LOAD_CYCLES)
  ) u_fsm (
    .clk        (clk),
    .srst_n     (srst_n),
    .chain_in_n (chain_in_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .done       (done)
  );

  cfgseq_qtable #(
    .NUM_Q     (NUM_Q),
    .MEM_WORDS (MEM_WORDS)
  ) u_tbl (
    .clk       (clk),
    .srst_n    (srst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .valid     (done),
    .q_count_o (q_count),
    .q_base_o  (q_base),
    .q_size_o  (q_size)
  );

  assign chain_out_n = ~done;

  // R5: the table is fully loaded by the time the chain output falls
  a_r5_count_at_finish: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(chain_out_n) |-> (q_count == SEL_W'(NUM_Q)));

  // R7: table reads zero while unconfigured
  a_r7_hidden_while_busy: assert property (@(posedge clk) disable iff (!srst_n)
    chain_out_n |-> (q_count == '0));
endmodule

// File: tb/cfg_chain_seq_test.sv
module cfg_chain_seq_test;
  localparam int NQ  = 4;
  localparam int MW  = 4096;
  localparam int LC  = 8;
  localparam int AW  = $clog2(MW);
  localparam int SW  = $clog2(MW + 1);
  localparam int CW  = $clog2(NQ + 1);
  localparam int QSZ = MW / NQ;

  logic clk;
  logic rst_n;
  logic cin_n;
  logic out0_n, out1_n, out2_n;
  logic [CW-1:0]    qc0, qc1, qc2;
  logic [NQ*AW-1:0] qb0, qb1, qb2;
  logic [NQ*SW-1:0] qs0, qs1, qs2;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  cfg_chain_seq #(.NUM_Q(NQ), .MEM_WORDS(MW), .LOAD_CYCLES(LC)) uut (
    .clk(clk), .rst_n(rst_n), .chain_in_n(cin_n), .chain_out_n(out0_n),
    .q_count(qc0), .q_base(qb0), .q_size(qs0));
  cfg_chain_seq #(.NUM_Q(NQ), .MEM_WORDS(MW), .LOAD_CYCLES(LC)) dev1 (
    .clk(clk), .rst_n(rst_n), .chain_in_n(out0_n), .chain_out_n(out1_n),
    .q_count(qc1), .q_base(qb1), .q_size(qs1));
  cfg_chain_seq #(.NUM_Q(NQ), .MEM_WORDS(MW), .LOAD_CYCLES(LC)) dev2 (
    .clk(clk), .rst_n(rst_n), .chain_in_n(out1_n), .chain_out_n(out2_n),
    .q_count(qc2), .q_base(qb2), .q_size(qs2));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  // edges until the selected chain output is low; sampled 1 time unit after each edge
  task automatic edges_to_low(input int which, input int limit, output int n);
    logic v;
    n = 0;
    for (int k = 1; k <= limit; k++) begin
      @(posedge clk); #1;
      v = (which == 0) ? out0_n : (which == 1) ? out1_n : out2_n;
      if (!v) begin n = k; return; end
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cin_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(out0_n == 1'b1, "R1", "chain_out_n in reset", out0_n, 1);
    chk(qc0 == '0, "R7", "q_count in reset", qc0, 0);
  endtask

  task automatic t_idle();
    @(negedge clk); rst_n = 1'b1;
    repeat (30) @(posedge clk);
    #1;
    chk(out0_n == 1'b1, "R2", "chain_out_n idle with enable high", out0_n, 1);
    chk(qb0 == '0 && qs0 == '0, "R7", "table zero while idle", qb0 == '0, 1);
  endtask

  task automatic t_chain_run();
    int n0, n1, n2;
    @(negedge clk); cin_n = 1'b0;
    edges_to_low(0, 100, n0);
    chk(n0 == LC + 1, "R3", "edges to first output low", n0, LC + 1);
    chk(out1_n == 1'b1 && qc1 == '0, "R7", "second device still hidden", out1_n, 1);
    edges_to_low(1, 100, n1);
    chk(n0 + n1 == 2 * (LC + 1), "R8", "edges to second output low", n0 + n1, 2 * (LC + 1));
    edges_to_low(2, 100, n2);
    chk(n0 + n1 + n2 == 3 * (LC + 1), "R8", "edges to last output low",
        n0 + n1 + n2, 3 * (LC + 1));
    chk(qc0 == CW'(NQ), "R5", "q_count after completion", qc0, NQ);
    chk(qc2 == CW'(NQ), "R5", "last device q_count", qc2, NQ);
    for (int i = 0; i < NQ; i++) begin
      chk(qb0[i*AW +: AW] == AW'(i * QSZ), "R6", $sformatf("base of queue %0d", i),
          qb0[i*AW +: AW], i * QSZ);
      chk(qs0[i*SW +: SW] == SW'(QSZ), "R6", $sformatf("size of queue %0d", i),
          qs0[i*SW +: SW], QSZ);
    end
  endtask

  task automatic t_ignore();
    logic [NQ*AW-1:0] keep_b;
    keep_b = qb0;
    @(negedge clk); cin_n = 1'b1;
    repeat (12) @(posedge clk);
    #1;
    chk(out0_n == 1'b0, "R4", "chain_out_n after enable raised", out0_n, 0);
    chk(qc0 == CW'(NQ) && qb0 == keep_b, "R4", "table unchanged after enable raised",
        qc0, NQ);
  endtask

  task automatic t_abort_restart();
    int n;
    @(negedge clk); rst_n = 1'b0;
    #1;
    chk(out0_n == 1'b1, "R1", "output high at once on reset", out0_n, 1);
    @(negedge clk); rst_n = 1'b1; cin_n = 1'b0;
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b0;
    #1;
    chk(out0_n == 1'b1, "R9", "output high after mid-load reset", out0_n, 1);
    chk(qc0 == '0 && qb0 == '0, "R9", "table cleared by mid-load reset", qc0, 0);
    @(negedge clk); rst_n = 1'b1;
    edges_to_low(0, 100, n);
    chk(n == LC + 3, "R10", "edges from reset release to output low", n, LC + 3);
    chk(qc0 == CW'(NQ), "R9", "q_count after restarted run", qc0, NQ);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_idle();
    t_chain_run();
    t_ignore();
    t_abort_restart();
    finish_run();
  end
endmodule